// File: doc/BRIEF.md
# Same-Address Busy Arbiter

This block sits beside a two-port memory and decides, cycle by cycle, which port may write when both ports point at the same word. Each port presents an enable, a write strobe and an address. When both ports are enabled on one address, the port that got there later is flagged busy on an active-low pin. The flagged port's write is withheld from the storage array through a write-permit output. The port that was already there keeps its access. The two busy pins are never low at the same time.

Arrival is judged in whole clock cycles. A port counts as present if it held the same address with its enable asserted on the previous edge. If both ports start colliding in the same cycle, the left port wins. The winner keeps priority for as long as the collision continues without a break. A compile-time parameter selects the role. As master, the block arbitrates and drives its busy pins push-pull. As slave, it does not arbitrate. It holds its busy outputs high and takes busy inputs from a master; a low busy input blocks that port's writes. There is no data stream here, so every pin is a plain level with no valid/ready handshake.

Top module: `dp_busy_arbiter`

## Requirements
- R1: When both ports are enabled but their addresses differ, both busy outputs are high (1).
- R2: When either port's enable is low, both busy outputs are high. A disabled port's write-permit output is 0.
- R3: If one port was already enabled on an address at the previous clock edge and the other port is new to it this cycle, the new port's busy output goes low (0) in the same cycle. The other busy output stays high.
- R4: If both ports begin colliding in the same cycle (neither was on that address at the previous edge), the right port's busy goes low and the left port's busy stays high.
- R5: busy_l_n and busy_r_n are never both low.
- R6: While both ports stay enabled on the same address from one edge to the next, the winner does not change, whichever rule chose it.
- R7: In master mode, a port whose busy output is low has write-permit 0 even when its write strobe is 1. The busy input pins have no effect on master behaviour.
- R8: In slave mode, both busy outputs are held high and no arbitration takes place. A low busy input on a side forces that side's write-permit to 0.
- R9: A port that is enabled, strobing a write and not blocked gets write-permit 1 in the same cycle. Write-permit is combinational from the inputs.
- R10: After reset, the arrival history is empty: the first collision after reset is resolved by the R4 rule, and both busy outputs are high while no port is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the arrival history |
| l_en | input | 1 | Left port enable, active high |
| l_wr | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port word address |
| r_en | input | 1 | Right port enable, active high |
| r_wr | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port word address |
| busy_l_in_n | input | 1 | Slave only: left busy from a master, active low |
| busy_r_in_n | input | 1 | Slave only: right busy from a master, active low |
| busy_l_n | output | 1 | Left busy, active low, push-pull |
| busy_r_n | output | 1 | Right busy, active low, push-pull |
| l_wr_ok | output | 1 | Left write permit to the storage array |
| r_wr_ok | output | 1 | Right write permit to the storage array |

## Verification
The bench builds two copies of the block with a 4-bit address. One copy is a master and the other a slave, and both are driven by the same port stimulus. The narrow address makes it easy to set up collisions, near misses and moves to a fresh shared address. The master copy's busy inputs are tied low, which shows that they are ignored. The slave copy's busy inputs are toggled on a colliding address, which shows that the slave only obeys its pins and never arbitrates on its own.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic [1:0] {
    WIN_NONE  = 2'd0,
    WIN_LEFT  = 2'd1,
    WIN_RIGHT = 2'd2
  } win_e;
endpackage

// File: rtl/dpb_side_track.sv
// Remembers one port's enable and address from the previous edge and
// reports whether the port is still parked on the same word.
module dpb_side_track #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              stayed
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  assign stayed = en && en_q && (addr == addr_q);
endmodule

// File: rtl/dpb_addr_cmp.sv
// Collision detect: both ports enabled on one word.
module dpb_addr_cmp #(
  parameter int ADDR_W = 17
) (
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              hit
);
  assign hit = l_en && r_en && (l_addr == r_addr);
endmodule

// File: rtl/dpb_priority.sv
// Picks the winner of a collision from the arrival history and keeps it
// while the collision continues unbroken.
module dpb_priority
  import dpb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic stay_l,
  input  logic stay_r,
  output win_e win
);
  win_e win_q;

  always_comb begin
    win = WIN_NONE;
    if (hit) begin
      if (stay_l && stay_r)
        win = (win_q == WIN_RIGHT) ? WIN_RIGHT : WIN_LEFT;
      else if (stay_r)
        win = WIN_RIGHT;
      else
        win = WIN_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= WIN_NONE;
    else        win_q <= win;
  end
endmodule

// File: rtl/dpb_write_gate.sv
// Role-dependent busy pins and write permits.
module dpb_write_gate #(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic l_en,
  input  logic l_wr,
  input  logic r_en,
  input  logic r_wr,
  input  logic arb_busy_l,
  input  logic arb_busy_r,
  input  logic pin_busy_l_n,
  input  logic pin_busy_r_n,
  output logic busy_l_n,
  output logic busy_r_n,
  output logic l_wr_ok,
  output logic r_wr_ok
);
  generate
    if (IS_MASTER) begin : g_master
      logic unused_pins;
      assign unused_pins = &{1'b0, pin_busy_l_n, pin_busy_r_n};
      assign busy_l_n = ~arb_busy_l;
      assign busy_r_n = ~arb_busy_r;
      assign l_wr_ok  = l_en && l_wr && !arb_busy_l;
      assign r_wr_ok  = r_en && r_wr && !arb_busy_r;
    end else begin : g_slave
      logic unused_arb;
      assign unused_arb = &{1'b0, arb_busy_l, arb_busy_r};
      assign busy_l_n = 1'b1;
      assign busy_r_n = 1'b1;
      assign l_wr_ok  = l_en && l_wr && pin_busy_l_n;
      assign r_wr_ok  = r_en && r_wr && pin_busy_r_n;
    end
  endgenerate
endmodule

// File: rtl/dp_busy_arbiter.sv
module dp_busy_arbiter
  import dpb_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_en,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              busy_l_in_n,
  input  logic              busy_r_in_n,
  output logic              busy_l_n,
  output logic              busy_r_n,
  output logic              l_wr_ok,
  output logic              r_wr_ok
);
  localparam int SIDES = 2;

  logic [SIDES-1:0]  en_v;
  logic [SIDES-1:0]  stay_v;
  logic [ADDR_W-1:0] addr_v [SIDES];
  logic              hit;
  win_e              win;

  assign en_v[0]   = l_en;
  assign en_v[1]   = r_en;
  assign addr_v[0] = l_addr;
  assign addr_v[1] = r_addr;

  generate
    for (genvar s = 0; s < SIDES; s++) begin : g_side
      dpb_side_track #(.ADDR_W(ADDR_W)) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en_v[s]),
        .addr   (addr_v[s]),
        .stayed (stay_v[s])
      );
    end
  endgenerate

  dpb_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .l_en   (l_en),
    .l_addr (l_addr),
    .r_en   (r_en),
    .r_addr (r_addr),
    .hit    (hit)
  );

  dpb_priority u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .stay_l (stay_v[0]),
    .stay_r (stay_v[1]),
    .win    (win)
  );

  dpb_write_gate #(.IS_MASTER(IS_MASTER)) u_gate (
    .l_en         (l_en),
    .l_wr         (l_wr),
    .r_en         (r_en),
    .r_wr         (r_wr),
    .arb_busy_l   (win == WIN_RIGHT),
    .arb_busy_r   (win == WIN_LEFT),
    .pin_busy_l_n (busy_l_in_n),
    .pin_busy_r_n (busy_r_in_n),
    .busy_l_n     (busy_l_n),
    .busy_r_n     (busy_r_n),
    .l_wr_ok      (l_wr_ok),
    .r_wr_ok      (r_wr_ok)
  );
endmodule

// File: rtl/dp_busy_arbiter_chk.sv
module dp_busy_arbiter_chk #(
  parameter int ADDR_W    = 17,
  parameter bit IS_MASTER = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_en,
  input logic              l_wr,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_en,
  input logic              r_wr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              busy_l_in_n,
  input logic              busy_r_in_n,
  input logic              busy_l_n,
  input logic              busy_r_n,
  input logic              l_wr_ok,
  input logic              r_wr_ok
);
  a_r5_never_both_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(!busy_l_n && !busy_r_n));

  a_r1_diff_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en && r_en && l_addr != r_addr) |-> (busy_l_n && busy_r_n));

  a_r2_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_en || !r_en) |-> (busy_l_n && busy_r_n));

  a_r6_winner_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && l_en && r_en && l_addr == r_addr && $stable(l_addr)
     && $stable(r_addr) && $past(l_en) && $past(r_en))
    |-> ($stable(busy_l_n) && $stable(busy_r_n)));

  a_r7_busy_left_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_MASTER && !busy_l_n) |-> !l_wr_ok);

  a_r7_busy_right_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_MASTER && !busy_r_n) |-> !r_wr_ok);

  a_r8_slave_pins_high: assert property (@(posedge clk) disable iff (!rst_n)
    !IS_MASTER |-> (busy_l_n && busy_r_n));

  a_r8_slave_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_MASTER && (!busy_l_in_n || !busy_r_in_n))
    |-> ((busy_l_in_n || !l_wr_ok) && (busy_r_in_n || !r_wr_ok)));

  a_r9_permit_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr_ok |-> (l_en && l_wr)) and (r_wr_ok |-> (r_en && r_wr)));
endmodule

bind dp_busy_arbiter dp_busy_arbiter_chk #(.ADDR_W(ADDR_W), .IS_MASTER(IS_MASTER)) u_chk (
  .clk(clk), .rst_n(rst_n), .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
  .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr), .busy_l_in_n(busy_l_in_n),
  .busy_r_in_n(busy_r_in_n), .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
  .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
);

// File: tb/test_dp_busy_arbiter.sv
`timescale 1ns/1ps
module test_dp_busy_arbiter;
  localparam int AW = 4;

  typedef struct {
    logic  bl, br, wl, wr;
    logic  sbl, sbr, swl, swr;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          l_en = 0, l_wr = 0, r_en = 0, r_wr = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          m_bin_l = 1'b0, m_bin_r = 1'b0;
  logic          s_bin_l = 1'b1, s_bin_r = 1'b1;
  logic          m_bl, m_br, m_wl, m_wr;
  logic          s_bl, s_br, s_wl, s_wr;

  int   checks = 0;
  int   failures = 0;
  bit   done = 0;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  dp_busy_arbiter #(.ADDR_W(AW), .IS_MASTER(1'b1)) i_dp_busy_arbiter (
    .clk(clk), .rst_n(rst_n), .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
    .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr),
    .busy_l_in_n(m_bin_l), .busy_r_in_n(m_bin_r),
    .busy_l_n(m_bl), .busy_r_n(m_br), .l_wr_ok(m_wl), .r_wr_ok(m_wr)
  );

  dp_busy_arbiter #(.ADDR_W(AW), .IS_MASTER(1'b0)) i_dp_busy_arbiter_slv (
    .clk(clk), .rst_n(rst_n), .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
    .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr),
    .busy_l_in_n(s_bin_l), .busy_r_in_n(s_bin_r),
    .busy_l_n(s_bl), .busy_r_n(s_br), .l_wr_ok(s_wl), .r_wr_ok(s_wr)
  );

  task automatic check(string what, string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus at the falling edge, queue expectation.
  task automatic step(input logic le, input int la, input logic lw,
                      input logic re, input int ra, input logic rw,
                      input logic sbl_in, input logic sbr_in,
                      input logic ebl, input logic ebr, input logic ewl, input logic ewr,
                      input logic eswl, input logic eswr, input string tag);
    exp_t e;
    @(negedge clk);
    l_en = le; l_addr = AW'(la); l_wr = lw;
    r_en = re; r_addr = AW'(ra); r_wr = rw;
    s_bin_l = sbl_in; s_bin_r = sbr_in;
    e.bl = ebl; e.br = ebr; e.wl = ewl; e.wr = ewr;
    e.sbl = 1'b1; e.sbr = 1'b1; e.swl = eswl; e.swr = eswr;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: shortly after each falling edge, compare against the queue.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check("master busy_l_n", e.tag, m_bl, e.bl);
        check("master busy_r_n", e.tag, m_br, e.br);
        check("master l_wr_ok", e.tag, m_wl, e.wl);
        check("master r_wr_ok", e.tag, m_wr, e.wr);
        check("slave busy_l_n R8", e.tag, s_bl, e.sbl);
        check("slave busy_r_n R8", e.tag, s_br, e.sbr);
        check("slave l_wr_ok", e.tag, s_wl, e.swl);
        check("slave r_wr_ok", e.tag, s_wr, e.swr);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: idle after reset
    step(0,0,0, 0,0,0, 1,1, 1,1,0,0, 0,0, "R10");
    // R1 distinct addresses, R9 writes pass
    step(1,3,1, 1,5,1, 1,1, 1,1,1,1, 1,1, "R1_R9");
    step(1,7,0, 1,5,0, 1,1, 1,1,0,0, 0,0, "R1");
    // R3 left already on 7, right arrives; R7 right write blocked, master pin ignored
    step(1,7,1, 1,7,1, 1,1, 1,0,1,0, 1,1, "R3_R7");
    step(1,7,1, 1,7,1, 1,1, 1,0,1,0, 1,1, "R6");
    // R2 left leaves
    step(0,7,0, 1,7,1, 1,1, 1,1,0,1, 0,1, "R2");
    // R3 reverse: right already there, left late
    step(1,7,1, 1,7,1, 1,1, 0,1,0,1, 1,1, "R3");
    step(1,7,1, 1,7,1, 1,1, 0,1,0,1, 1,1, "R6");
    step(1,7,1, 1,8,1, 1,1, 1,1,1,1, 1,1, "R1");
    // R4 both move to 2 together
    step(1,2,1, 1,2,1, 1,1, 1,0,1,0, 1,1, "R4");
    step(1,2,0, 1,2,0, 1,1, 1,0,0,0, 0,0, "R6");
    step(0,2,0, 0,2,0, 1,1, 1,1,0,0, 0,0, "R2");
    step(1,9,1, 1,9,1, 1,1, 1,0,1,0, 1,1, "R4");
    step(0,4,1, 0,4,1, 1,1, 1,1,0,0, 0,0, "R2");
    // R8 slave inhibited by its pins
    step(1,3,1, 1,6,1, 0,1, 1,1,1,1, 0,1, "R8");
    step(1,3,1, 1,6,1, 1,0, 1,1,1,1, 1,0, "R8");
    step(1,5,1, 1,5,1, 0,1, 1,0,1,0, 0,1, "R8_R4");
    @(negedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule